// File: doc/BRIEF.md
# Bus Master Error-Policy Sequencer

This block is the request side of a single-master AHB-Lite port. A user pushes simple transfer requests into a small queue. Each request carries an address, a read/write flag, write data, a group tag and a bufferable flag. The block issues the requests as NONSEQ single transfers, with the address phase of one transfer overlapping the data phase of the one before. Each request returns exactly one response, in issue order. The response status is OKAY, ERROR or CANCELLED.

The block reacts to a two-cycle ERROR response according to a policy input, which it samples only while no transfer is on the bus.

- **Cancel policy.** The block detects the error in its first cycle, while HREADY is still low. It then withdraws the transfer waiting in its address phase, so the bus shows IDLE before HREADY rises. It also withdraws every queued request that shares the failing transfer's group tag. The slave therefore never sees a later access after an earlier one has failed.
- **Continue policy.** The error cycles count only as a wait state, and the next transfer goes ahead.
- **Bufferable writes.** A bufferable write that fails is always handled as under the continue policy.

Every failure is recorded in a small error log. The log holds the address of the latest failing transfer, a sticky flag and a saturating count. A user strobe clears the flag and the count.

Top module: `ahbm_err_seq`

## Requirements
- R1: After reset, htrans_o is IDLE (2'b00), rsp_valid_o and err_flag_o are 0, err_cnt_o is 0 and req_ready_o is 1.
- R2: Zero-wait requests that are queued back to back are issued in consecutive cycles, so each address phase overlaps the data phase of the transfer before it. Write data appears on hwdata_o during the data phase.
- R3: Each request yields exactly one rsp_valid_o pulse, in issue order. rsp_status_o is 0 for OKAY, 1 for ERROR and 2 for CANCELLED. rsp_addr_o is the request address. rsp_rdata_o carries the read data of an OKAY read.
- R4: While HREADY is low and HRESP is OKAY, the address and control of the pending transfer hold steady.
- R5: Under the cancel policy (policy_cancel_i = 1), the cycle after an ERROR first cycle (hresp_i = 1, hready_i = 0) shows htrans_o IDLE. The transfer that was waiting in its address phase is then never accepted by the slave and returns CANCELLED.
- R6: Under the cancel policy, queued requests with the failing transfer's group tag also return CANCELLED without reaching the bus. The first queued request with a different tag is issued normally.
- R7: Under the continue policy (policy_cancel_i = 0), the next transfer stays NONSEQ through both ERROR cycles and is issued. The failing transfer returns ERROR.
- R8: A failing write with the bufferable flag set is handled as under the continue policy, even when the cancel policy is selected.
- R9: hsize_o is 3'b010 (word). hprot_o is {1'b0, bufferable & write, 1'b0, 1'b1}, so hprot_o[2] is 1 only for bufferable writes.
- R10: Each ERROR completion sets err_flag_o, loads err_addr_o with that transfer's address and increments err_cnt_o, which saturates at its maximum (15). An err_clr_i pulse clears the flag and the count unless an error completes in the same cycle.
- R11: policy_cancel_i is taken only while no transfer is in its address or data phase. A change made while transfers are in flight does not affect them.
- R12: req_ready_o is low while the queue is full. No request is lost or duplicated when the queue fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_cancel_i | input | 1 | 1 selects the cancel policy, 0 the continue policy |
| req_valid_i | input | 1 | Request push strobe |
| req_ready_o | output | 1 | Queue can accept a request |
| req_addr_i | input | ADDR_W | Request address |
| req_write_i | input | 1 | 1 for a write |
| req_wdata_i | input | DATA_W | Write data |
| req_grp_i | input | GRP_W | Group tag |
| req_buf_i | input | 1 | Bufferable flag |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_status_o | output | 2 | 0 OKAY, 1 ERROR, 2 CANCELLED |
| rsp_addr_o | output | ADDR_W | Address of the responding request |
| rsp_rdata_o | output | DATA_W | Read data (zero otherwise) |
| err_clr_i | input | 1 | Clears the error flag and count |
| err_flag_o | output | 1 | Sticky error flag |
| err_addr_o | output | ADDR_W | Address of the latest failing transfer |
| err_cnt_o | output | ECNT_W | Saturating error count |
| haddr_o | output | ADDR_W | Bus address |
| htrans_o | output | 2 | Bus transfer type |
| hwrite_o | output | 1 | Bus write flag |
| hsize_o | output | 3 | Bus transfer size |
| hprot_o | output | 4 | Bus protection attributes |
| hwdata_o | output | DATA_W | Bus write data |
| hrdata_i | input | DATA_W | Bus read data |
| hready_i | input | 1 | Bus ready |
| hresp_i | input | 1 | Bus response, 1 for ERROR |

## Verification
The bench builds the block with FIFO_DEPTH = 4. With that depth, a stream of wait-state transfers fills the queue within a few cycles, so the full-queue stall and the recovery from it are reached. The package widths stay at their defaults: 32-bit address and data, 4-bit group tag and a 4-bit error count. The 4-bit count saturates after 15 errors, so seventeen failing reads are enough to show saturation. The bench's slave model decodes address bit 12 as a two-cycle ERROR and address bit 13 as one wait state. This lets each scenario set the error and wait pattern through its addresses alone.

// File: rtl/ahbm_err_pkg.sv
package ahbm_err_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int GRP_W  = 4;
    parameter int ECNT_W = 4;

    localparam logic [1:0] HTRANS_IDLE   = 2'b00;
    localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
    localparam logic [2:0] HSIZE_WORD    = 3'($clog2(DATA_W / 8));

    typedef enum logic [1:0] {
        ST_OKAY   = 2'd0,
        ST_ERROR  = 2'd1,
        ST_CANCEL = 2'd2
    } rsp_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [GRP_W-1:0]  grp;
        logic              bufw;
    } req_t;

    typedef struct packed {
        logic valid;
        logic cancel;
        req_t req;
    } slot_t;

    // bufferable write: its failure never withdraws later traffic
    function automatic logic err_exempt(req_t r);
        return r.write && r.bufw;
    endfunction

    function automatic logic [3:0] prot_bits(req_t r);
        return {1'b0, r.write && r.bufw, 1'b0, 1'b1};
    endfunction
endpackage

// File: rtl/ahbm_req_fifo.sv
module ahbm_req_fifo
    import ahbm_err_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  req_t push_data_i,
    output logic full_o,
    input  logic pop_i,
    output req_t head_o,
    output logic empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    req_t             store [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (cnt_q == FULL_CNT);
    assign empty_o = (cnt_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = store[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) store[wr_q] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R12
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (full_o && !pop_i) |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/ahbm_pipe.sv
module ahbm_pipe
    import ahbm_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              policy_cancel_i,
    input  req_t              head_i,
    input  logic              empty_i,
    output logic              pop_o,
    output logic [ADDR_W-1:0] haddr_o,
    output logic [1:0]        htrans_o,
    output logic              hwrite_o,
    output logic [2:0]        hsize_o,
    output logic [3:0]        hprot_o,
    output logic [DATA_W-1:0] hwdata_o,
    input  logic [DATA_W-1:0] hrdata_i,
    input  logic              hready_i,
    input  logic              hresp_i,
    output logic              done_valid_o,
    output logic [1:0]        done_status_o,
    output logic [ADDR_W-1:0] done_addr_o,
    output logic [DATA_W-1:0] done_rdata_o
);
    slot_t            ap_q, dp_q;
    logic             pol_q;
    logic             purge_q;
    logic [GRP_W-1:0] purge_grp_q;
    logic             in_flight, err_first, kill, head_drop;
    rsp_st_e          retire_st;

    assign in_flight = ap_q.valid || dp_q.valid;
    // first ERROR cycle of a real (not withdrawn) data phase
    assign err_first = dp_q.valid && !dp_q.cancel && hresp_i && !hready_i;
    assign kill      = err_first && pol_q && !err_exempt(dp_q.req);
    assign head_drop = purge_q && (head_i.grp == purge_grp_q);
    assign pop_o     = hready_i && !empty_i;

    assign htrans_o = (ap_q.valid && !ap_q.cancel) ? HTRANS_NONSEQ : HTRANS_IDLE;
    assign haddr_o  = ap_q.req.addr;
    assign hwrite_o = ap_q.req.write;
    assign hsize_o  = HSIZE_WORD;
    assign hprot_o  = prot_bits(ap_q.req);
    assign hwdata_o = dp_q.req.wdata;

    always_comb begin
        if (dp_q.cancel)  retire_st = ST_CANCEL;
        else if (hresp_i) retire_st = ST_ERROR;
        else              retire_st = ST_OKAY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ap_q          <= '0;
            dp_q          <= '0;
            pol_q         <= 1'b0;
            purge_q       <= 1'b0;
            purge_grp_q   <= '0;
            done_valid_o  <= 1'b0;
            done_status_o <= 2'd0;
            done_addr_o   <= '0;
            done_rdata_o  <= '0;
        end else begin
            if (!in_flight) pol_q <= policy_cancel_i;
            done_valid_o <= 1'b0;
            if (hready_i) begin
                if (dp_q.valid) begin
                    done_valid_o  <= 1'b1;
                    done_status_o <= retire_st;
                    done_addr_o   <= dp_q.req.addr;
                    done_rdata_o  <= (retire_st == ST_OKAY && !dp_q.req.write) ? hrdata_i : '0;
                end
                dp_q        <= ap_q;
                ap_q.valid  <= !empty_i;
                ap_q.cancel <= !empty_i && head_drop;
                ap_q.req    <= head_i;
            end else if (kill && ap_q.valid) begin
                ap_q.cancel <= 1'b1;
            end
            if (kill) begin
                purge_q     <= 1'b1;
                purge_grp_q <= dp_q.req.grp;
            end else if (purge_q && (empty_i || head_i.grp != purge_grp_q)) begin
                purge_q <= 1'b0;
            end
        end
    end

    // R4
    hold_on_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (htrans_o == HTRANS_NONSEQ && !hready_i && !hresp_i)
        |=> (htrans_o == HTRANS_NONSEQ && $stable(haddr_o)));

    // R5
    cancel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_q.valid && !dp_q.cancel && hresp_i && !hready_i && pol_q && !err_exempt(dp_q.req))
        |=> (htrans_o == HTRANS_IDLE));

    // R7
    continue_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_q.valid && hresp_i && !hready_i && !pol_q && htrans_o == HTRANS_NONSEQ)
        |=> (htrans_o == HTRANS_NONSEQ && $stable(haddr_o)));

    // R11
    policy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        in_flight |=> $stable(pol_q));
endmodule

// File: rtl/ahbm_err_log.sv
module ahbm_err_log
    import ahbm_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_valid_i,
    input  logic [1:0]        done_status_i,
    input  logic [ADDR_W-1:0] done_addr_i,
    input  logic              err_clr_i,
    output logic              err_flag_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [ECNT_W-1:0] err_cnt_o
);
    localparam logic [ECNT_W-1:0] CNT_MAX = '1;

    logic hit;
    assign hit = done_valid_i && (done_status_i == ST_ERROR);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag_o <= 1'b0;
            err_addr_o <= '0;
            err_cnt_o  <= '0;
        end else if (hit) begin
            err_flag_o <= 1'b1;
            err_addr_o <= done_addr_i;
            if (err_clr_i)                err_cnt_o <= ECNT_W'(1);
            else if (err_cnt_o != CNT_MAX) err_cnt_o <= err_cnt_o + 1'b1;
        end else if (err_clr_i) begin
            err_flag_o <= 1'b0;
            err_cnt_o  <= '0;
        end
    end

    // R10
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (err_clr_i && !hit) |=> (!err_flag_o && err_cnt_o == '0));

    // R10
    err_record_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (err_flag_o && err_addr_o == $past(done_addr_i)));
endmodule

// File: rtl/ahbm_err_seq.sv
module ahbm_err_seq
    import ahbm_err_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              policy_cancel_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              req_write_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [GRP_W-1:0]  req_grp_i,
    input  logic              req_buf_i,
    output logic              rsp_valid_o,
    output logic [1:0]        rsp_status_o,
    output logic [ADDR_W-1:0] rsp_addr_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    input  logic              err_clr_i,
    output logic              err_flag_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [ECNT_W-1:0] err_cnt_o,
    output logic [ADDR_W-1:0] haddr_o,
    output logic [1:0]        htrans_o,
    output logic              hwrite_o,
    output logic [2:0]        hsize_o,
    output logic [3:0]        hprot_o,
    output logic [DATA_W-1:0] hwdata_o,
    input  logic [DATA_W-1:0] hrdata_i,
    input  logic              hready_i,
    input  logic              hresp_i
);
    req_t in_req, head;
    logic full, empty, pop;

    assign in_req.addr  = req_addr_i;
    assign in_req.write = req_write_i;
    assign in_req.wdata = req_wdata_i;
    assign in_req.grp   = req_grp_i;
    assign in_req.bufw  = req_buf_i;
    assign req_ready_o  = !full;

    ahbm_req_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_i(req_valid_i), .push_data_i(in_req),
        .full_o(full), .pop_i(pop), .head_o(head), .empty_o(empty)
    );

    ahbm_pipe u_pipe (
        .clk(clk), .rst(rst), .policy_cancel_i(policy_cancel_i),
        .head_i(head), .empty_i(empty), .pop_o(pop),
        .haddr_o(haddr_o), .htrans_o(htrans_o), .hwrite_o(hwrite_o),
        .hsize_o(hsize_o), .hprot_o(hprot_o), .hwdata_o(hwdata_o),
        .hrdata_i(hrdata_i), .hready_i(hready_i), .hresp_i(hresp_i),
        .done_valid_o(rsp_valid_o), .done_status_o(rsp_status_o),
        .done_addr_o(rsp_addr_o), .done_rdata_o(rsp_rdata_o)
    );

    ahbm_err_log u_log (
        .clk(clk), .rst(rst), .done_valid_i(rsp_valid_o),
        .done_status_i(rsp_status_o), .done_addr_i(rsp_addr_o),
        .err_clr_i(err_clr_i), .err_flag_o(err_flag_o),
        .err_addr_o(err_addr_o), .err_cnt_o(err_cnt_o)
    );
endmodule

// File: tb/test_ahbm_err_seq.sv
`timescale 1ns/1ps
module test_ahbm_err_seq;
    localparam logic [31:0] RMASK = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        policy_cancel_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_addr_i = '0;
    logic        req_write_i = 1'b0;
    logic [31:0] req_wdata_i = '0;
    logic [3:0]  req_grp_i = '0;
    logic        req_buf_i = 1'b0;
    logic        rsp_valid_o;
    logic [1:0]  rsp_status_o;
    logic [31:0] rsp_addr_o, rsp_rdata_o;
    logic        err_clr_i = 1'b0;
    logic        err_flag_o;
    logic [31:0] err_addr_o;
    logic [3:0]  err_cnt_o;
    logic [31:0] haddr_o, hwdata_o, hrdata_i;
    logic [1:0]  htrans_o;
    logic        hwrite_o, hready_i, hresp_i;
    logic [2:0]  hsize_o;
    logic [3:0]  hprot_o;

    ahbm_err_seq #(.FIFO_DEPTH(4)) i_ahbm_err_seq (
        .clk(clk), .rst(rst), .policy_cancel_i(policy_cancel_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_addr_i(req_addr_i), .req_write_i(req_write_i),
        .req_wdata_i(req_wdata_i), .req_grp_i(req_grp_i), .req_buf_i(req_buf_i),
        .rsp_valid_o(rsp_valid_o), .rsp_status_o(rsp_status_o),
        .rsp_addr_o(rsp_addr_o), .rsp_rdata_o(rsp_rdata_o),
        .err_clr_i(err_clr_i), .err_flag_o(err_flag_o),
        .err_addr_o(err_addr_o), .err_cnt_o(err_cnt_o),
        .haddr_o(haddr_o), .htrans_o(htrans_o), .hwrite_o(hwrite_o),
        .hsize_o(hsize_o), .hprot_o(hprot_o), .hwdata_o(hwdata_o),
        .hrdata_i(hrdata_i), .hready_i(hready_i), .hresp_i(hresp_i)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- slave model: bit 12 -> ERROR, bit 13 -> one wait
    logic        s_act, s_err, s_wait, s_ph, s_wr;
    logic [31:0] s_addr;
    int          seen_n;
    logic [31:0] seen_addr [0:255];
    int          seen_cyc  [0:255];
    logic [3:0]  seen_prot [0:255];
    logic [2:0]  seen_size [0:255];
    logic [1:0]  ph2_htrans;
    logic [31:0] last_wdata, wait_addr;
    logic        wait_seen, stab_bad;

    assign hready_i = !s_act ? 1'b1 : (s_err ? s_ph : !s_wait);
    assign hresp_i  = s_act && s_err;
    assign hrdata_i = (s_act && !s_wr) ? (s_addr ^ RMASK) : 32'h0;

    always @(posedge clk) begin
        if (rst) begin
            s_act <= 1'b0; s_err <= 1'b0; s_wait <= 1'b0; s_ph <= 1'b0; s_wr <= 1'b0;
            s_addr <= '0; seen_n <= 0; ph2_htrans <= 2'b11; last_wdata <= '0;
            wait_addr <= '0; wait_seen <= 1'b0; stab_bad <= 1'b0;
        end else if (hready_i) begin
            if (s_act && s_err) ph2_htrans <= htrans_o;
            if (s_act && s_wr)  last_wdata <= hwdata_o;
            if (htrans_o == 2'b10) begin
                if (seen_n < 256) begin
                    seen_addr[seen_n] <= haddr_o;
                    seen_cyc[seen_n]  <= cyc;
                    seen_prot[seen_n] <= hprot_o;
                    seen_size[seen_n] <= hsize_o;
                end
                seen_n <= seen_n + 1;
                s_act <= 1'b1; s_err <= haddr_o[12]; s_wait <= haddr_o[13];
                s_ph <= 1'b0; s_wr <= hwrite_o; s_addr <= haddr_o;
                if (wait_seen && haddr_o != wait_addr) stab_bad <= 1'b1;
            end else begin
                s_act <= 1'b0;
            end
            wait_seen <= 1'b0;
        end else begin
            if (s_err) s_ph <= 1'b1;
            else       s_wait <= 1'b0;
            if (!s_err && htrans_o == 2'b10) begin
                if (wait_seen && haddr_o != wait_addr) stab_bad <= 1'b1;
                wait_addr <= haddr_o;
                wait_seen <= 1'b1;
            end
        end
    end

    // ---------------- response monitor
    int          r_n = 0;
    logic [1:0]  r_st   [0:255];
    logic [31:0] r_addr [0:255];
    logic [31:0] r_data [0:255];
    logic        saw_full = 1'b0;
    always @(negedge clk) begin
        if (!rst && rsp_valid_o && r_n < 256) begin
            r_st[r_n] = rsp_status_o;
            r_addr[r_n] = rsp_addr_o;
            r_data[r_n] = rsp_rdata_o;
            r_n = r_n + 1;
        end
        if (!rst && !req_ready_o) saw_full = 1'b1;
    end

    // ---------------- bookkeeping
    int  n_chk = 0, n_bad = 0;
    bit  ended = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d,
                        input logic [3:0] g, input logic b);
        req_valid_i = 1'b1; req_addr_i = a; req_write_i = w;
        req_wdata_i = d; req_grp_i = g; req_buf_i = b;
        while (!req_ready_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic req_off();
        req_valid_i = 1'b0;
    endtask

    task automatic wait_rsp(input int n);
        for (int t = 0; t < 400 && r_n < n; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_policy(input logic p);
        policy_cancel_i = p;
        repeat (3) @(negedge clk);
    endtask

    // ---------------- scenarios
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 htrans idle", htrans_o, 2'b00);
        chk("R1 rsp_valid", rsp_valid_o, 0);
        chk("R1 err_flag", err_flag_o, 0);
        chk("R1 err_cnt", err_cnt_o, 0);
        chk("R1 req_ready", req_ready_o, 1);
    endtask

    task automatic t_pipeline();
        int rb, sb;
        set_policy(1'b0);
        rb = r_n; sb = seen_n;
        push(32'h0000_0100, 1'b1, 32'hCAFE_0001, 4'd1, 1'b1);
        push(32'h0000_0204, 1'b0, 32'h0, 4'd1, 1'b1);
        push(32'h0000_0308, 1'b0, 32'h0, 4'd1, 1'b0);
        req_off();
        wait_rsp(rb + 3);
        chk("R2 issued count", seen_n - sb, 3);
        chk("R2 consecutive a1", seen_cyc[sb+1] - seen_cyc[sb], 1);
        chk("R2 consecutive a2", seen_cyc[sb+2] - seen_cyc[sb+1], 1);
        chk("R2 write data", last_wdata, 32'hCAFE_0001);
        chk("R3 rsp count", r_n - rb, 3);
        chk("R3 st0", r_st[rb], 0);
        chk("R3 addr1", r_addr[rb+1], 32'h204);
        chk("R3 rdata1", r_data[rb+1], 32'h204 ^ RMASK);
        chk("R3 rdata2", r_data[rb+2], 32'h308 ^ RMASK);
        chk("R9 hprot bufw write", seen_prot[sb], 4'b0101);
        chk("R9 hprot buf read", seen_prot[sb+1], 4'b0001);
        chk("R9 hsize", seen_size[sb], 3'b010);
    endtask

    task automatic t_wait();
        int rb, sb;
        rb = r_n; sb = seen_n;
        push(32'h0000_2010, 1'b0, 32'h0, 4'd2, 1'b0);
        push(32'h0000_0014, 1'b0, 32'h0, 4'd2, 1'b0);
        req_off();
        wait_rsp(rb + 2);
        chk("R4 address stable", stab_bad, 0);
        chk("R4 wait spacing", seen_cyc[sb+1] - seen_cyc[sb], 2);
        chk("R4 rdata wait", r_data[rb], 32'h2010 ^ RMASK);
        chk("R4 status next", r_st[rb+1], 0);
    endtask

    task automatic t_cancel_group();
        int rb, sb;
        set_policy(1'b1);
        rb = r_n; sb = seen_n;
        push(32'h0000_1000, 1'b0, 32'h0, 4'd1, 1'b0);
        push(32'h0000_0040, 1'b0, 32'h0, 4'd1, 1'b0);
        push(32'h0000_0044, 1'b0, 32'h0, 4'd1, 1'b0);
        push(32'h0000_0048, 1'b0, 32'h0, 4'd2, 1'b0);
        req_off();
        wait_rsp(rb + 4);
        chk("R5 idle in second error cycle", ph2_htrans, 2'b00);
        chk("R5 first status ERROR", r_st[rb], 1);
        chk("R5 next CANCELLED", r_st[rb+1], 2);
        chk("R6 group mate CANCELLED", r_st[rb+2], 2);
        chk("R6 other group OKAY", r_st[rb+3], 0);
        chk("R6 other group rdata", r_data[rb+3], 32'h48 ^ RMASK);
        chk("R3 cancel order addr", r_addr[rb+2], 32'h44);
        chk("R5 slave saw two", seen_n - sb, 2);
        chk("R6 slave saw other group", seen_addr[sb+1], 32'h48);
        chk("R10 err_addr", err_addr_o, 32'h1000);
        chk("R10 err_flag", err_flag_o, 1);
    endtask

    task automatic t_continue();
        int rb, sb;
        set_policy(1'b0);
        rb = r_n; sb = seen_n;
        push(32'h0000_1004, 1'b0, 32'h0, 4'd3, 1'b0);
        push(32'h0000_0050, 1'b0, 32'h0, 4'd3, 1'b0);
        req_off();
        wait_rsp(rb + 2);
        chk("R7 next kept NONSEQ", ph2_htrans, 2'b10);
        chk("R7 status ERROR", r_st[rb], 1);
        chk("R7 next OKAY", r_st[rb+1], 0);
        chk("R7 slave saw both", seen_n - sb, 2);
    endtask

    task automatic t_bufw();
        int rb, sb;
        set_policy(1'b1);
        rb = r_n; sb = seen_n;
        push(32'h0000_1008, 1'b1, 32'hBEEF_0008, 4'd4, 1'b1);
        push(32'h0000_0058, 1'b0, 32'h0, 4'd4, 1'b0);
        req_off();
        wait_rsp(rb + 2);
        chk("R8 next kept NONSEQ", ph2_htrans, 2'b10);
        chk("R8 status ERROR", r_st[rb], 1);
        chk("R8 next OKAY", r_st[rb+1], 0);
        chk("R8 slave saw both", seen_n - sb, 2);
        chk("R9 hprot bufw", seen_prot[sb], 4'b0101);
        chk("R2 bufw write data", last_wdata, 32'hBEEF_0008);
    endtask

    task automatic t_errlog();
        int rb;
        @(negedge clk); err_clr_i = 1'b1;
        @(negedge clk); err_clr_i = 1'b0;
        chk("R10 cleared flag", err_flag_o, 0);
        chk("R10 cleared count", err_cnt_o, 0);
        set_policy(1'b0);
        rb = r_n;
        for (int i = 0; i < 17; i++)
            push(32'h0000_1000 + 32'(i * 4), 1'b0, 32'h0, 4'(i), 1'b0);
        req_off();
        wait_rsp(rb + 17);
        chk("R10 count saturates", err_cnt_o, 4'd15);
        chk("R10 flag set", err_flag_o, 1);
        chk("R10 latest address", err_addr_o, 32'h0000_1040);
        @(negedge clk); err_clr_i = 1'b1;
        @(negedge clk); err_clr_i = 1'b0;
        chk("R10 clear after errors", {err_flag_o, err_cnt_o}, 0);
    endtask

    task automatic t_policy_sample();
        int rb, sb;
        set_policy(1'b0);
        rb = r_n; sb = seen_n;
        push(32'h0000_100C, 1'b0, 32'h0, 4'd5, 1'b0);
        push(32'h0000_0060, 1'b0, 32'h0, 4'd5, 1'b0);
        policy_cancel_i = 1'b1;
        req_off();
        wait_rsp(rb + 2);
        chk("R11 late change ignored", r_st[rb+1], 0);
        chk("R11 slave saw both", seen_n - sb, 2);
    endtask

    task automatic t_full();
        int rb;
        set_policy(1'b0);
        saw_full = 1'b0;
        rb = r_n;
        for (int i = 0; i < 12; i++)
            push(32'h0000_2000 + 32'(i * 4), 1'b0, 32'h0, 4'd6, 1'b0);
        req_off();
        wait_rsp(rb + 12);
        chk("R12 ready dropped", saw_full, 1);
        chk("R12 no loss", r_n - rb, 12);
        chk("R12 last address", r_addr[rb+11], 32'h2000 + 32'd44);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pipeline();
        t_wait();
        t_cancel_group();
        t_continue();
        t_bufw();
        t_errlog();
        t_policy_sample();
        t_full();
        finish_run();
    end
endmodule